// File: doc/BRIEF.md
# Zero Suppression and Cluster Packer

This block sits at the end of one readout channel's digital filter chain. It receives a stream of baseline-corrected 10-bit samples, each tagged with its time bin, and keeps only the stretches that carry signal. A run of samples that exceeds a programmable threshold counts as a pulse only if it lasts at least a programmed minimum length. Shorter runs are treated as glitches and dropped. Around every accepted pulse, a programmed number of earlier and later samples is also kept. Kept stretches separated by a gap of one or two samples are joined into one cluster.

Each cluster is written out as its samples in time order, followed by a time word and a length word. All 10-bit values are packed four to a 40-bit word. When the end-of-event strobe arrives, the block drains its internal delay line. It fills any partly used last word with a filler code and then emits a trailer word. The trailer holds the channel hardware address and the number of 10-bit values in the event.

Samples leading up to a pulse are held in a tag line that is deep enough for the largest minimum-length setting plus the largest pre-sample setting. This lets a pulse mark earlier samples as kept before they leave the line. Two further stages give the lookahead that gap merging needs.

Top module: `zsup_cluster_packer`

## Requirements
- R1: After reset, out_valid is low and no word is produced until an event is ended.
- R2: Only a sample strictly greater than cfg_thresh can start or extend a pulse. An event with no such sample produces only a trailer with count 0 and no filler word.
- R3: A run of above-threshold samples shorter than cfg_min_len (which is at least 1) is dropped unless other rules keep it.
- R4: Up to cfg_pre samples before the first sample of an accepted pulse are kept, clipped at the event start.
- R5: Up to cfg_post samples after the last sample of an accepted pulse are kept, clipped at the event end.
- R6: Two kept stretches separated by one or two unkept samples are merged into one cluster, with the gap samples emitted. A gap of three or more samples keeps them separate.
- R7: After each cluster's samples come two values: first the time bin of the cluster's last sample, then the number of samples plus 2.
- R8: The 10-bit values are packed in order, four per word. The earliest value goes in bits [9:0], then [19:10], [29:20], [39:30].
- R9: If the event's values do not fill the last word, the unused slots carry the filler 10'h2AA. No filler word is produced when the count is a multiple of 4.
- R10: The event ends with a trailer word {12'hAAA, cfg_hw_addr[11:0], count[15:0]}. The count is the number of 10-bit values, not including filler.
- R11: After a sample with in_eoe, no sample is accepted for DEPTH+3 cycles, where DEPTH = MAX_PRE + MAX_MIN + 3. The trailer is produced within that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_eoe | input | 1 | Marks the last sample of the event |
| in_sample | input | 10 | Baseline-corrected sample value |
| in_tbin | input | 10 | Time bin of the sample |
| cfg_thresh | input | 10 | Pulse threshold (strictly greater keeps) |
| cfg_min_len | input | 3 | Minimum pulse length, 1 to MAX_MIN |
| cfg_pre | input | 3 | Samples kept before a pulse |
| cfg_post | input | 3 | Samples kept after a pulse |
| cfg_hw_addr | input | 12 | Channel hardware address for the trailer |
| out_valid | output | 1 | out_word holds a packed word |
| out_word | output | 40 | Packed data, filler or trailer word |

## Verification
The checker takes three things as given about the inputs. Configuration is stable for the whole event. cfg_min_len is never zero. No sample arrives during the drain window that follows an end-of-event strobe. The bench changes configuration only between events and always waits more than DEPTH+3 idle cycles after the strobe. It draws cfg_min_len from 1 to 7. Inside an event, it inserts random idle cycles between samples to show that only accepted samples advance the tag line.

// File: rtl/zsup_pkg.sv
package zsup_pkg;

    localparam int SMP_W = 10;
    localparam int HWA_W = 12;
    localparam int CNT_W = 16;
    localparam logic [SMP_W-1:0] FILLER_CODE = 10'h2AA;
    localparam logic [11:0] TRAILER_TAG = 12'hAAA;

    typedef struct packed {
        logic             vld;
        logic             keep;
        logic [SMP_W-1:0] smp;
        logic [SMP_W-1:0] tb;
    } tag_entry_t;

    typedef enum logic [1:0] {PH_RUN, PH_DRAIN, PH_PAD, PH_TRAIL} phase_e;

    function automatic logic [4*SMP_W-1:0] pack4(input logic [SMP_W-1:0] a,
                                                  input logic [SMP_W-1:0] b,
                                                  input logic [SMP_W-1:0] c,
                                                  input logic [SMP_W-1:0] d);
        return {d, c, b, a};
    endfunction

endpackage

// File: rtl/zsup_tag_line.sv
module zsup_tag_line
    import zsup_pkg::*;
#(
    parameter int MAX_PRE  = 7,
    parameter int MAX_MIN  = 7,
    parameter int MAX_POST = 7,
    localparam int DEPTH = MAX_PRE + MAX_MIN + 3,
    localparam int CW    = $clog2(MAX_MIN + 1),
    localparam int PW    = $clog2(MAX_PRE + 1),
    localparam int QW    = $clog2(MAX_POST + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             in_valid,
    input  logic             in_eoe,
    input  logic [SMP_W-1:0] in_sample,
    input  logic [SMP_W-1:0] in_tbin,
    input  logic [SMP_W-1:0] thresh,
    input  logic [CW-1:0]    min_len,
    input  logic [PW-1:0]    pre_len,
    input  logic [QW-1:0]    post_len,
    output tag_entry_t       tail,
    output logic [1:0]       ahead_vld,
    output logic [1:0]       ahead_keep
);

    tag_entry_t line_q [DEPTH];
    tag_entry_t line_d [DEPTH];
    logic [CW-1:0] run_q, run_d;
    logic [QW-1:0] post_q;
    logic above, pulse, validate, cur_keep;
    int span;

    always_comb begin
        above    = in_valid && (in_sample > thresh);
        run_d    = (run_q == CW'(MAX_MIN)) ? run_q : run_q + 1'b1;
        if (!above) run_d = '0;
        pulse    = above && (run_d >= min_len);
        validate = above && (run_d == min_len);
        cur_keep = pulse || (post_q != '0);
        span     = int'(min_len) + int'(pre_len);
        line_d[0] = '{vld: in_valid, keep: in_valid && cur_keep, smp: in_sample, tb: in_tbin};
        for (int i = 1; i < DEPTH; i++) begin
            line_d[i] = line_q[i-1];
            if (validate && (i < span)) line_d[i].keep = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
            run_q  <= '0;
            post_q <= '0;
        end else begin
            if (shift) begin
                for (int i = 0; i < DEPTH; i++) line_q[i] <= line_d[i];
            end
            if (in_valid) begin
                if (in_eoe) begin
                    run_q  <= '0;
                    post_q <= '0;
                end else begin
                    run_q <= run_d;
                    if (pulse)              post_q <= post_len;
                    else if (post_q != '0)  post_q <= post_q - 1'b1;
                end
            end
        end
    end

    assign tail       = line_q[DEPTH-1];
    assign ahead_vld  = {line_q[DEPTH-3].vld,  line_q[DEPTH-2].vld};
    assign ahead_keep = {line_q[DEPTH-3].keep, line_q[DEPTH-2].keep};

endmodule

// File: rtl/zsup_framer.sv
module zsup_framer
    import zsup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  tag_entry_t       tail,
    input  logic [1:0]       ahead_vld,
    input  logic [1:0]       ahead_keep,
    output logic [1:0]       add_n,
    output logic [SMP_W-1:0] val0,
    output logic [SMP_W-1:0] val1,
    output logic             closing
);

    logic             open_q;
    logic [SMP_W-1:0] len_q, last_tb_q;
    logic             bridge, take;

    always_comb begin
        // a gap of one or two samples is bridged if a kept sample follows
        bridge  = open_q && ahead_vld[0] &&
                  (ahead_keep[0] || (ahead_vld[1] && ahead_keep[1]));
        take    = shift && tail.vld && (tail.keep || bridge);
        closing = shift && open_q && !take;
        add_n   = take ? 2'd1 : (closing ? 2'd2 : 2'd0);
        val0    = take ? tail.smp : last_tb_q;
        val1    = len_q + 10'd2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            len_q     <= '0;
            last_tb_q <= '0;
        end else if (take) begin
            open_q    <= 1'b1;
            len_q     <= open_q ? len_q + 10'd1 : 10'd1;
            last_tb_q <= tail.tb;
        end else if (closing) begin
            open_q <= 1'b0;
        end
    end

endmodule

// File: rtl/zsup_word_packer.sv
module zsup_word_packer
    import zsup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       add_n,
    input  logic [SMP_W-1:0] val0,
    input  logic [SMP_W-1:0] val1,
    input  logic             do_pad,
    input  logic             do_trail,
    input  logic [HWA_W-1:0] hw_addr,
    output logic             out_valid,
    output logic [4*SMP_W-1:0] out_word
);

    logic [SMP_W-1:0] hold_q [3];
    logic [1:0]       hcnt_q;
    logic [CNT_W-1:0] nval_q;
    logic [SMP_W-1:0] slot [5];
    logic [SMP_W-1:0] padv [3];
    logic [2:0]       total;

    always_comb begin
        total = {1'b0, hcnt_q} + {1'b0, add_n};
        for (int j = 0; j < 3; j++) begin
            if (j < int'(hcnt_q))       slot[j] = hold_q[j];
            else if (j == int'(hcnt_q)) slot[j] = val0;
            else                        slot[j] = val1;
            padv[j] = (j < int'(hcnt_q)) ? hold_q[j] : FILLER_CODE;
        end
        slot[3] = (hcnt_q == 2'd3) ? val0 : val1;
        slot[4] = val1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < 3; j++) hold_q[j] <= '0;
            hcnt_q    <= '0;
            nval_q    <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (do_trail) begin
                out_valid <= 1'b1;
                out_word  <= {TRAILER_TAG, hw_addr, nval_q};
                nval_q    <= '0;
            end else if (do_pad) begin
                if (hcnt_q != 2'd0) begin
                    out_valid <= 1'b1;
                    out_word  <= pack4(padv[0], padv[1], padv[2], FILLER_CODE);
                end
                hcnt_q <= '0;
            end else if (add_n != 2'd0) begin
                nval_q <= nval_q + CNT_W'(add_n);
                if (total >= 3'd4) begin
                    out_valid <= 1'b1;
                    out_word  <= pack4(slot[0], slot[1], slot[2], slot[3]);
                    hold_q[0] <= slot[4];
                    hcnt_q    <= 2'(total - 3'd4);
                end else begin
                    for (int j = 0; j < 3; j++) hold_q[j] <= slot[j];
                    hcnt_q <= total[1:0];
                end
            end
        end
    end

endmodule

// File: rtl/zsup_cluster_packer.sv
module zsup_cluster_packer
    import zsup_pkg::*;
#(
    parameter int MAX_PRE  = 7,
    parameter int MAX_MIN  = 7,
    parameter int MAX_POST = 7,
    localparam int DEPTH = MAX_PRE + MAX_MIN + 3,
    localparam int CW    = $clog2(MAX_MIN + 1),
    localparam int PW    = $clog2(MAX_PRE + 1),
    localparam int QW    = $clog2(MAX_POST + 1),
    localparam int DW    = $clog2(DEPTH + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_eoe,
    input  logic [SMP_W-1:0]   in_sample,
    input  logic [SMP_W-1:0]   in_tbin,
    input  logic [SMP_W-1:0]   cfg_thresh,
    input  logic [CW-1:0]      cfg_min_len,
    input  logic [PW-1:0]      cfg_pre,
    input  logic [QW-1:0]      cfg_post,
    input  logic [HWA_W-1:0]   cfg_hw_addr,
    output logic               out_valid,
    output logic [4*SMP_W-1:0] out_word
);

    phase_e          phase_q;
    logic [DW-1:0]   dcnt_q;
    logic            accept, shift, do_pad, do_trail;
    tag_entry_t      tail;
    logic [1:0]      ahead_vld, ahead_keep;
    logic [1:0]      frm_n;
    logic [SMP_W-1:0] frm_v0, frm_v1;
    logic            frm_close;

    assign accept   = in_valid && (phase_q == PH_RUN);
    assign shift    = accept || (phase_q == PH_DRAIN);
    assign do_pad   = (phase_q == PH_PAD);
    assign do_trail = (phase_q == PH_TRAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
            dcnt_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_RUN: if (accept && in_eoe) begin
                    phase_q <= PH_DRAIN;
                    dcnt_q  <= DW'(DEPTH + 1);
                end
                PH_DRAIN: begin
                    dcnt_q <= dcnt_q - 1'b1;
                    if (dcnt_q == DW'(1)) phase_q <= PH_PAD;
                end
                PH_PAD:   phase_q <= PH_TRAIL;
                PH_TRAIL: phase_q <= PH_RUN;
                default:  phase_q <= PH_RUN;
            endcase
        end
    end

    zsup_tag_line #(.MAX_PRE(MAX_PRE), .MAX_MIN(MAX_MIN), .MAX_POST(MAX_POST)) u_line (
        .clk(clk), .rst(rst), .shift(shift), .in_valid(accept), .in_eoe(in_eoe),
        .in_sample(in_sample), .in_tbin(in_tbin), .thresh(cfg_thresh),
        .min_len(cfg_min_len), .pre_len(cfg_pre), .post_len(cfg_post),
        .tail(tail), .ahead_vld(ahead_vld), .ahead_keep(ahead_keep)
    );

    zsup_framer u_framer (
        .clk(clk), .rst(rst), .shift(shift), .tail(tail),
        .ahead_vld(ahead_vld), .ahead_keep(ahead_keep),
        .add_n(frm_n), .val0(frm_v0), .val1(frm_v1), .closing(frm_close)
    );

    zsup_word_packer u_packer (
        .clk(clk), .rst(rst), .add_n(frm_n), .val0(frm_v0), .val1(frm_v1),
        .do_pad(do_pad), .do_trail(do_trail), .hw_addr(cfg_hw_addr),
        .out_valid(out_valid), .out_word(out_word)
    );

endmodule

// File: rtl/zsup_checker.sv
module zsup_checker #(
    parameter int DEPTH = 17,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_eoe,
    input logic [CW-1:0] cfg_min_len,
    input logic          out_valid,
    input logic [15:0]   trailer_cnt,
    input logic [1:0]    fr_n,
    input logic          fr_close,
    input logic [9:0]    fr_len,
    input logic          trail_step
);

    logic [7:0]  quiet_q;
    logic [15:0] val_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q   <= '0;
            val_cnt_q <= '0;
        end else begin
            if (in_valid && in_eoe && quiet_q == '0) quiet_q <= 8'(DEPTH + 3);
            else if (quiet_q != '0)                   quiet_q <= quiet_q - 8'd1;
            if (trail_step) val_cnt_q <= '0;
            else            val_cnt_q <= val_cnt_q + 16'(fr_n);
        end
    end

    assert_quiet_after_eoe_R11: assert property (@(posedge clk) disable iff (rst)
        (quiet_q != '0) |-> !in_valid);

    assert_min_len_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (cfg_min_len != '0));

    assert_length_word_R7: assert property (@(posedge clk) disable iff (rst)
        fr_close |-> (fr_len >= 10'd3));

    assert_cluster_gap_R6: assert property (@(posedge clk) disable iff (rst)
        fr_close |=> !fr_close);

    assert_trailer_count_R10: assert property (@(posedge clk) disable iff (rst)
        trail_step |=> (out_valid && trailer_cnt == $past(val_cnt_q)));

endmodule

bind zsup_cluster_packer zsup_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_eoe(in_eoe),
    .cfg_min_len(cfg_min_len), .out_valid(out_valid), .trailer_cnt(out_word[15:0]),
    .fr_n(frm_n), .fr_close(frm_close), .fr_len(frm_v1), .trail_step(do_trail)
);

// File: tb/zsup_cluster_packer_bench.sv
module zsup_cluster_packer_bench;

    localparam int DEPTH = 17;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_eoe;
    logic [9:0]  in_sample, in_tbin, cfg_thresh;
    logic [2:0]  cfg_min_len, cfg_pre, cfg_post;
    logic [11:0] cfg_hw_addr;
    logic        out_valid;
    logic [39:0] out_word;

    always #4 clk = ~clk;

    zsup_cluster_packer u_zsup_cluster_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_eoe(in_eoe),
        .in_sample(in_sample), .in_tbin(in_tbin), .cfg_thresh(cfg_thresh),
        .cfg_min_len(cfg_min_len), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .cfg_hw_addr(cfg_hw_addr), .out_valid(out_valid), .out_word(out_word)
    );

    int checks = 0;
    int failures = 0;
    logic [39:0] got_q[$];
    logic [39:0] exp_q[$];
    int ev_smp[64];
    int ev_n;
    int ev_tb0;

    always @(negedge clk) if (!rst && out_valid) got_q.push_back(out_word);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void build_expected();
        bit keep[64];
        bit fill[64];
        int vals[$];
        int i, s, e, a, b;
        int len, last;
        logic [39:0] w;
        for (int k = 0; k < 64; k++) begin keep[k] = 0; fill[k] = 0; end
        i = 0;
        while (i < ev_n) begin
            if (ev_smp[i] > int'(cfg_thresh)) begin
                s = i;
                while (i < ev_n && ev_smp[i] > int'(cfg_thresh)) i++;
                e = i - 1;
                if (e - s + 1 >= int'(cfg_min_len))
                    for (int j = s - int'(cfg_pre); j <= e + int'(cfg_post); j++)
                        if (j >= 0 && j < ev_n) keep[j] = 1;
            end else i++;
        end
        i = 0;
        while (i < ev_n) begin
            if (!keep[i]) begin
                a = i;
                while (i < ev_n && !keep[i]) i++;
                b = i - 1;
                if (a > 0 && b < ev_n - 1 && (b - a + 1) <= 2)
                    for (int j = a; j <= b; j++) fill[j] = 1;
            end else i++;
        end
        for (int k = 0; k < ev_n; k++) keep[k] = keep[k] | fill[k];
        len = 0; last = 0;
        for (int k = 0; k <= ev_n; k++) begin
            if (k < ev_n && keep[k]) begin
                vals.push_back(ev_smp[k]); len++; last = k;
            end else if (len > 0) begin
                vals.push_back((ev_tb0 + last) & 32'h3FF);
                vals.push_back(len + 2);
                len = 0;
            end
        end
        for (int k = 0; k < vals.size(); k += 4) begin
            for (int m = 0; m < 4; m++)
                w[m*10 +: 10] = (k + m < vals.size()) ? 10'(vals[k+m]) : 10'h2AA;
            exp_q.push_back(w);
        end
        exp_q.push_back({12'hAAA, cfg_hw_addr, 16'(vals.size())});
    endfunction

    task automatic drive_event(input int idle_pct);
        for (int i = 0; i < ev_n; i++) begin
            while (($urandom % 100) < idle_pct) begin
                @(negedge clk); in_valid = 1'b0; in_eoe = 1'b0;
            end
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 10'(ev_smp[i]);
            in_tbin   = 10'(ev_tb0 + i);
            in_eoe    = (i == ev_n - 1);
        end
        @(negedge clk); in_valid = 1'b0; in_eoe = 1'b0;
        repeat (DEPTH + 6) @(negedge clk);
    endtask

    task automatic run_and_check(input string tag, input int idle_pct);
        got_q.delete(); exp_q.delete();
        build_expected();
        drive_event(idle_pct);
        chk(got_q.size() == exp_q.size(), tag, "word count",
            40'(got_q.size()), 40'(exp_q.size()));
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
            chk(got_q[k] === exp_q[k], tag, $sformatf("word %0d", k), got_q[k], exp_q[k]);
    endtask

    task automatic set_cfg(input int thr, input int mn, input int pre, input int post);
        cfg_thresh = 10'(thr); cfg_min_len = 3'(mn); cfg_pre = 3'(pre); cfg_post = 3'(post);
    endtask

    task automatic clear_event(input int n, input int base);
        ev_n = n;
        for (int k = 0; k < 64; k++) ev_smp[k] = base;
    endtask

    initial begin
        logic [39:0] tw;
        void'($urandom(32'd2718));
        rst = 1'b1; in_valid = 1'b0; in_eoe = 1'b0; in_sample = '0; in_tbin = '0;
        set_cfg(50, 1, 0, 0); cfg_hw_addr = 12'h5C3; ev_tb0 = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: quiet output after reset
        got_q.delete();
        repeat (10) @(negedge clk);
        chk(out_valid == 1'b0 && got_q.size() == 0, "R1", "idle after reset",
            40'(got_q.size()), 40'd0);

        // R2: samples at or below threshold give only a trailer
        set_cfg(50, 1, 2, 2); clear_event(12, 10); ev_smp[4] = 50; ev_smp[5] = 50;
        run_and_check("R2", 0);
        chk(got_q.size() == 1, "R2", "only trailer", 40'(got_q.size()), 40'd1);
        if (got_q.size() > 0)
            chk(got_q[0] == {12'hAAA, 12'h5C3, 16'd0}, "R10", "empty trailer", got_q[0],
                {12'hAAA, 12'h5C3, 16'd0});

        // R3: glitch shorter than minimum dropped, then exact minimum kept
        set_cfg(50, 3, 0, 0); clear_event(14, 5); ev_smp[3] = 90; ev_smp[4] = 91;
        run_and_check("R3", 0);
        chk(got_q.size() == 1, "R3", "glitch dropped", 40'(got_q.size()), 40'd1);
        ev_smp[5] = 92;
        run_and_check("R3", 0);

        // R4: pre-samples, including clipping at the event start
        set_cfg(50, 2, 3, 0); clear_event(16, 7); ev_smp[8] = 200; ev_smp[9] = 201;
        run_and_check("R4", 0);
        clear_event(10, 7); ev_smp[1] = 300; ev_smp[2] = 301;
        run_and_check("R4", 0);

        // R5: post-samples, including clipping at the event end
        set_cfg(50, 1, 0, 4); clear_event(16, 3); ev_smp[5] = 150;
        run_and_check("R5", 0);
        clear_event(8, 3); ev_smp[6] = 150;
        run_and_check("R5", 0);

        // R6: gap of two merges, gap of three separates
        set_cfg(50, 1, 0, 0); clear_event(20, 1);
        ev_smp[3] = 99; ev_smp[6] = 98; ev_smp[10] = 97;
        run_and_check("R6", 0);
        chk(got_q.size() == 4, "R6", "two clusters size", 40'(got_q.size()), 40'd4);

        // R7 R8: hand-built expectation for one cluster
        set_cfg(50, 1, 0, 0); ev_tb0 = 100; clear_event(8, 0);
        ev_smp[2] = 400; ev_smp[3] = 401;
        run_and_check("R7", 0);
        tw = {10'd4, 10'd103, 10'd401, 10'd400};
        if (got_q.size() > 0) chk(got_q[0] == tw, "R8", "packed order", got_q[0], tw);

        // R9: padded last word
        clear_event(8, 0); ev_smp[2] = 400;
        run_and_check("R9", 0);
        tw = {10'h2AA, 10'd3, 10'd102, 10'd400};
        if (got_q.size() > 0) chk(got_q[0] == tw, "R9", "filler slot", got_q[0], tw);
        if (got_q.size() > 1)
            chk(got_q[1] == {12'hAAA, 12'h5C3, 16'd3}, "R10", "trailer fields", got_q[1],
                {12'hAAA, 12'h5C3, 16'd3});

        // random events with idle gaps, configuration changed between events
        for (int ev = 0; ev < 40; ev++) begin
            int n;
            set_cfg(60, 1 + $urandom % 7, $urandom % 8, $urandom % 8);
            cfg_hw_addr = 12'($urandom);
            ev_tb0 = $urandom % 1024;
            n = 8 + $urandom % 48;
            clear_event(n, 0);
            for (int k = 0; k < n; k++) begin
                ev_smp[k] = $urandom % 60;
                if ($urandom % 100 < 20) begin
                    int bl = 1 + $urandom % 5;
                    for (int m = 0; m < bl && k < n; m++) begin
                        ev_smp[k] = 61 + $urandom % 900;
                        if (m < bl - 1) k++;
                    end
                end
            end
            run_and_check((ev % 2 == 0) ? "R8" : "R10", 25);
            if (got_q.size() > 0) begin
                tw = got_q[got_q.size()-1];
                chk(tw[39:16] == {12'hAAA, cfg_hw_addr}, "R10", "trailer tag/addr",
                    40'(tw[39:16]), 40'({12'hAAA, cfg_hw_addr}));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R11 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule